// File: doc/BRIEF.md
# Delta-Sigma Converter Bring-Up and Sample Sequencer

This block sits on the host side of a serial link to an external delta-sigma converter. It drives a byte-level serial master through a request/acknowledge handshake. After reset it soft-resets the converter, then configures its clocking and digital filter. The configuration is the one of eleven fixed clock setups whose total divide ratio is nearest to a requested ratio. It then strobes a sync line so the new filter settings take effect.

Once configured, the host can ask for a free-running stream or for a single conversion. In streaming mode every rising edge of the converter's data-ready line fetches one 24-bit word. The word appears on the sample output with a one-cycle valid strobe. A stop request ends streaming with a command read of the data register. A reconfiguration request that arrives during streaming waits until that stop has finished. A single conversion switches the converter to one-shot mode, waits a bounded time for data-ready, reads the result and returns the converter to continuous mode.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the first two frames write 0x03 and then 0x02 to register 0x1D. A write frame is two bytes: the register address with bits 7:6 clear, then the data byte. A read command byte is the address OR 0x40.
- R2: The candidate ratios are 16·2^k for k = 0..10. The selected one has the smallest absolute difference to the requested ratio (BOOT_RATIO after reset, otherwise the last `cfg_ratio` taken with `cfg_req`). When two candidates tie, the lower ratio is chosen.
- R3: The byte written to register 0x15 is (divider code << 4) | power code. Ratios 16..256 give 0x33, 512..4096 give 0x22, 8192 gives 0x12 and 16384 gives 0x00.
- R4: The byte written to register 0x19 depends on the decimation, which is the ratio divided by the clock divider. Decimation 8 gives 0x10 and decimation 16 gives 0x20. Decimations 32, 64, 128, 256, 512 and 1024 give 0x00, 0x01, 0x02, 0x03, 0x04 and 0x05.
- R5: A configuration writes register 0x15 and then register 0x19, then raises `sync_out`. No byte request is made while `sync_out` is high. `ready` rises only after `sync_out` has fallen.
- R6: `sync_out` stays high for max(`sync_len`, 2) clock cycles.
- R7: A start request writes 0x01 to register 0x14. After that, each rising edge of `drdy` starts a 3-byte frame of 0x00 bytes with no command byte. The three received bytes, first byte most significant, appear on `sample_data` with `sample_valid` high for exactly one cycle.
- R8: A rising edge of `drdy` during a streaming sample read starts no extra frame and increments `overrun_cnt` by one.
- R9: A stop request during streaming sends the 4-byte frame 0x6C, 0x00, 0x00, 0x00, produces no sample, and returns to `ready`. Once stopped, `drdy` edges start no frames.
- R10: A `cfg_req` during streaming sends no bytes until the stop frame has completed. The configuration frames follow right after it.
- R11: A single request writes 0x01 to register 0x18 and waits for a `drdy` rising edge. It then sends 0x6C, 0x00, 0x00, 0x00 and presents the last three received bytes as a sample. Finally it writes 0x00 to register 0x18.
- R12: If no `drdy` rising edge arrives within TIMEOUT_CYC cycles of a single request's wait, `timeout_err` goes high and stays high until the next single request. The 0x18/0x00 write follows and no sample is produced.
- R13: `xfer_last` is high on the final byte of every frame and low on all others. `xfer_tx` holds steady while a request waits for its acknowledge.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | One-cycle request to reconfigure using `cfg_ratio` |
| cfg_ratio | input | RATIO_W | Requested total divide ratio |
| sync_len | input | SYNC_W | Sync pulse length in cycles (minimum 2 applied) |
| start_req | input | 1 | One-cycle request to enter streaming |
| stop_req | input | 1 | One-cycle request to leave streaming |
| single_req | input | 1 | One-cycle request for one conversion |
| drdy | input | 1 | Converter data-ready line |
| xfer_ack | input | 1 | Serial master: current byte finished |
| xfer_rx | input | 8 | Serial master: byte received, valid with `xfer_ack` |
| xfer_req | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_last | output | 1 | Current byte ends the frame |
| sync_out | output | 1 | Filter sync pulse to converter |
| ready | output | 1 | Idle and accepting requests |
| streaming | output | 1 | Continuous-read mode active |
| sample_data | output | 24 | Last sample, unsigned, MSB first |
| sample_valid | output | 1 | One-cycle strobe for `sample_data` |
| overrun_cnt | output | OVR_W | Count of data-ready edges lost to a busy read (wraps) |
| timeout_err | output | 1 | Single conversion saw no data-ready in time |

## Verification
The assertions rely on the serial master raising `xfer_ack` only while `xfer_req` is high, and for one cycle per byte. The bench's master model acknowledges each byte two cycles after it sees the request and drops the acknowledge on the following cycle. The design also assumes `drdy` is low when a single conversion starts its wait. The bench returns `drdy` low after every pulse and leaves it low through each request. Every request is a single-cycle pulse driven between clock edges.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int NUM_CFG = 11;

  localparam logic [5:0] A_SOFTRST = 6'h1D;
  localparam logic [5:0] A_PWRCLK  = 6'h15;
  localparam logic [5:0] A_FILTER  = 6'h19;
  localparam logic [5:0] A_IFACE   = 6'h14;
  localparam logic [5:0] A_CONV    = 6'h18;
  localparam logic [5:0] A_DATA    = 6'h2C;
  localparam logic [7:0] RD_FLAG   = 8'h40;

  typedef enum logic [3:0] {
    ST_BOOT, ST_RST_A, ST_RST_B, ST_PICK, ST_PWR, ST_FILT, ST_SYNC, ST_IDLE,
    ST_STR_EN, ST_STREAM, ST_STR_RD, ST_STR_EXIT,
    ST_ONE_SET, ST_ONE_WAIT, ST_ONE_RD, ST_ONE_RST
  } seq_state_t;

  function automatic logic [7:0] wr_cmd(input logic [5:0] a);
    return {2'b00, a};
  endfunction

  function automatic logic [7:0] rd_cmd(input logic [5:0] a);
    return RD_FLAG | {2'b00, a};
  endfunction

  // total divide ratio of candidate i
  function automatic int cfg_ratio(input int i);
    return 16 << i;
  endfunction

  // log2 of the master-clock divider for candidate i
  function automatic int cfg_div_log2(input int i);
    if (i <= 4)      return 1;
    else if (i <= 8) return 2;
    else if (i == 9) return 3;
    else             return 4;
  endfunction

  function automatic logic [7:0] cfg_pwr_byte(input int i);
    int pcode;
    int dcode;
    dcode = 4 - cfg_div_log2(i);
    if (i <= 4)      pcode = 3;
    else if (i <= 9) pcode = 2;
    else             pcode = 0;
    return 8'((dcode << 4) | pcode);
  endfunction

  function automatic logic [7:0] cfg_filt_byte(input int i);
    int dl;
    int code;
    dl = i + 4 - cfg_div_log2(i);
    if (dl < 5) begin
      code = dl + 6;
      return {1'b0, 3'(code), 4'b0000};
    end
    code = dl - 5;
    return {5'b0, 3'(code)};
  endfunction

endpackage

// File: rtl/adc_ratio_pick.sv
module adc_ratio_pick
  import adc_seq_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RATIO_W-1:0] ratio,
  output logic               vld,
  output logic [7:0]         pwr_byte,
  output logic [7:0]         filt_byte
);
  localparam int DW    = ((RATIO_W > 15) ? RATIO_W : 15) + 1;
  localparam int IDX_W = $clog2(NUM_CFG);

  logic [DW-1:0]    req_ext;
  logic [DW-1:0]    diff [NUM_CFG];
  logic [IDX_W-1:0] best;
  logic [DW-1:0]    best_d;

  assign req_ext = DW'(ratio);

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_diff
    localparam logic [DW-1:0] TGT = DW'(cfg_ratio(g));
    assign diff[g] = (req_ext >= TGT) ? (req_ext - TGT) : (TGT - req_ext);
  end

  // strict less-than while scanning upward: lower ratio wins a tie
  always_comb begin
    best   = '0;
    best_d = diff[0];
    for (int i = 1; i < NUM_CFG; i++) begin
      if (diff[i] < best_d) begin
        best_d = diff[i];
        best   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= 1'b0;
      pwr_byte  <= 8'h00;
      filt_byte <= 8'h00;
    end else begin
      vld <= load;
      if (load) begin
        pwr_byte  <= cfg_pwr_byte(int'(best));
        filt_byte <= cfg_filt_byte(int'(best));
      end
    end
  end

  assert_pick_latency_R2: assert property (@(posedge clk) disable iff (rst)
    vld |-> $past(load));

endmodule

// File: rtl/adc_frame_xfer.sv
module adc_frame_xfer #(
  parameter int MAXB     = 4,
  parameter int SAMPLE_W = 24,
  localparam int IW = $clog2(MAXB),
  localparam int CW = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CW-1:0]        nbytes,
  input  logic [MAXB-1:0][7:0] bytes,
  input  logic                 xfer_ack,
  input  logic [7:0]           xfer_rx,
  output logic                 xfer_req,
  output logic [7:0]           xfer_tx,
  output logic                 xfer_last,
  output logic                 done,
  output logic [SAMPLE_W-1:0]  rx_word
);
  logic [MAXB-1:0][7:0] buf_q;
  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q;
  logic                 on_last;

  assign on_last   = (CW'(idx_q) == (cnt_q - CW'(1)));
  assign xfer_tx   = buf_q[idx_q];
  assign xfer_last = xfer_req && on_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      xfer_req <= 1'b0;
      done     <= 1'b0;
      rx_word  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !xfer_req) begin
        buf_q    <= bytes;
        cnt_q    <= nbytes;
        idx_q    <= '0;
        xfer_req <= 1'b1;
      end else if (xfer_req && xfer_ack) begin
        rx_word <= {rx_word[SAMPLE_W-9:0], xfer_rx};
        if (on_last) begin
          xfer_req <= 1'b0;
          done     <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  assert_ack_in_req_R13: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> xfer_req);

endmodule

// File: rtl/adc_sync_gen.sv
module adc_sync_gen #(
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SYNC_W-1:0] len,
  output logic              sync_out,
  output logic              done
);
  logic [SYNC_W-1:0] len_eff;
  logic [SYNC_W-1:0] cnt_q;

  assign len_eff = (len < SYNC_W'(2)) ? SYNC_W'(2) : len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_out <= 1'b0;
      done     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !sync_out) begin
        sync_out <= 1'b1;
        cnt_q    <= len_eff - SYNC_W'(1);
      end else if (sync_out) begin
        if (cnt_q == '0) begin
          sync_out <= 1'b0;
          done     <= 1'b1;
        end else begin
          cnt_q <= cnt_q - SYNC_W'(1);
        end
      end
    end
  end

  assert_sync_min_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |=> sync_out);

  assert_done_low_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !sync_out);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RATIO_W     = 16,
  parameter int BOOT_RATIO  = 512,
  parameter int SYNC_W      = 8,
  parameter int TIMEOUT_CYC = 100000,
  parameter int OVR_W       = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_req,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [SYNC_W-1:0]  sync_len,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic               single_req,
  input  logic               drdy,
  input  logic               xfer_ack,
  input  logic [7:0]         xfer_rx,
  output logic               xfer_req,
  output logic [7:0]         xfer_tx,
  output logic               xfer_last,
  output logic               sync_out,
  output logic               ready,
  output logic               streaming,
  output logic [23:0]        sample_data,
  output logic               sample_valid,
  output logic [OVR_W-1:0]   overrun_cnt,
  output logic               timeout_err
);
  localparam int MAXB = 4;
  localparam int CW   = $clog2(MAXB) + 1;
  localparam int TW   = $clog2(TIMEOUT_CYC + 1);
  localparam int SW   = 24;

  seq_state_t state_q;
  logic fr_start_q, pick_ld_q, sync_st_q;
  logic cfg_pend, start_pend, single_pend, stop_pend;
  logic [RATIO_W-1:0] ratio_q;
  logic drdy_q, drdy_rise;
  logic [TW-1:0] tmo_cnt;
  logic in_stream;

  logic [MAXB-1:0][7:0] fr_bytes;
  logic [CW-1:0]        fr_n;
  logic                 fr_done;
  logic [SW-1:0]        rx_word;
  logic                 pick_vld;
  logic [7:0]           pwr_byte, filt_byte;
  logic                 sync_done;

  assign drdy_rise = drdy & ~drdy_q;
  assign in_stream = (state_q == ST_STR_EN) || (state_q == ST_STREAM) ||
                     (state_q == ST_STR_RD);
  assign ready     = (state_q == ST_IDLE);
  assign streaming = (state_q == ST_STREAM) || (state_q == ST_STR_RD);

  // frame contents follow the state the frame is launched in
  always_comb begin
    fr_bytes = '0;
    fr_n     = CW'(2);
    case (state_q)
      ST_RST_A:    begin fr_bytes[0] = wr_cmd(A_SOFTRST); fr_bytes[1] = 8'h03; end
      ST_RST_B:    begin fr_bytes[0] = wr_cmd(A_SOFTRST); fr_bytes[1] = 8'h02; end
      ST_PWR:      begin fr_bytes[0] = wr_cmd(A_PWRCLK);  fr_bytes[1] = pwr_byte; end
      ST_FILT:     begin fr_bytes[0] = wr_cmd(A_FILTER);  fr_bytes[1] = filt_byte; end
      ST_STR_EN:   begin fr_bytes[0] = wr_cmd(A_IFACE);   fr_bytes[1] = 8'h01; end
      ST_ONE_SET:  begin fr_bytes[0] = wr_cmd(A_CONV);    fr_bytes[1] = 8'h01; end
      ST_ONE_RST:  begin fr_bytes[0] = wr_cmd(A_CONV);    fr_bytes[1] = 8'h00; end
      ST_STR_RD:   fr_n = CW'(3);
      ST_STR_EXIT,
      ST_ONE_RD:   begin fr_bytes[0] = rd_cmd(A_DATA); fr_n = CW'(4); end
      default:     ;
    endcase
  end

  adc_frame_xfer #(.MAXB(MAXB), .SAMPLE_W(SW)) u_frame (
    .clk(clk), .rst(rst), .start(fr_start_q), .nbytes(fr_n), .bytes(fr_bytes),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_last(xfer_last), .done(fr_done), .rx_word(rx_word)
  );

  adc_ratio_pick #(.RATIO_W(RATIO_W)) u_pick (
    .clk(clk), .rst(rst), .load(pick_ld_q), .ratio(ratio_q),
    .vld(pick_vld), .pwr_byte(pwr_byte), .filt_byte(filt_byte)
  );

  adc_sync_gen #(.SYNC_W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .start(sync_st_q), .len(sync_len),
    .sync_out(sync_out), .done(sync_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_BOOT;
      fr_start_q   <= 1'b0;
      pick_ld_q    <= 1'b0;
      sync_st_q    <= 1'b0;
      cfg_pend     <= 1'b0;
      start_pend   <= 1'b0;
      single_pend  <= 1'b0;
      stop_pend    <= 1'b0;
      ratio_q      <= RATIO_W'(BOOT_RATIO);
      drdy_q       <= 1'b0;
      tmo_cnt      <= '0;
      sample_data  <= '0;
      sample_valid <= 1'b0;
      overrun_cnt  <= '0;
      timeout_err  <= 1'b0;
    end else begin
      fr_start_q   <= 1'b0;
      pick_ld_q    <= 1'b0;
      sync_st_q    <= 1'b0;
      sample_valid <= 1'b0;
      drdy_q       <= drdy;
      case (state_q)
        ST_BOOT: begin state_q <= ST_RST_A; fr_start_q <= 1'b1; end
        ST_RST_A: if (fr_done) begin state_q <= ST_RST_B; fr_start_q <= 1'b1; end
        ST_RST_B: if (fr_done) begin state_q <= ST_PICK; pick_ld_q <= 1'b1; end
        ST_PICK:  if (pick_vld) begin state_q <= ST_PWR; fr_start_q <= 1'b1; end
        ST_PWR:   if (fr_done) begin state_q <= ST_FILT; fr_start_q <= 1'b1; end
        ST_FILT:  if (fr_done) begin state_q <= ST_SYNC; sync_st_q <= 1'b1; end
        ST_SYNC:  if (sync_done) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (cfg_pend) begin
            cfg_pend  <= 1'b0;
            state_q   <= ST_PICK;
            pick_ld_q <= 1'b1;
          end else if (single_pend) begin
            single_pend <= 1'b0;
            timeout_err <= 1'b0;
            state_q     <= ST_ONE_SET;
            fr_start_q  <= 1'b1;
          end else if (start_pend) begin
            start_pend <= 1'b0;
            state_q    <= ST_STR_EN;
            fr_start_q <= 1'b1;
          end
        end
        ST_STR_EN: if (fr_done) state_q <= ST_STREAM;
        ST_STREAM: begin
          if (stop_pend) begin
            stop_pend  <= 1'b0;
            state_q    <= ST_STR_EXIT;
            fr_start_q <= 1'b1;
          end else if (drdy_rise) begin
            state_q    <= ST_STR_RD;
            fr_start_q <= 1'b1;
          end
        end
        ST_STR_RD: begin
          if (drdy_rise) overrun_cnt <= overrun_cnt + OVR_W'(1);
          if (fr_done) begin
            sample_data  <= rx_word;
            sample_valid <= 1'b1;
            state_q      <= ST_STREAM;
          end
        end
        ST_STR_EXIT: if (fr_done) state_q <= ST_IDLE;
        ST_ONE_SET: if (fr_done) begin state_q <= ST_ONE_WAIT; tmo_cnt <= '0; end
        ST_ONE_WAIT: begin
          if (drdy_rise) begin
            state_q    <= ST_ONE_RD;
            fr_start_q <= 1'b1;
          end else if (tmo_cnt == TW'(TIMEOUT_CYC - 1)) begin
            timeout_err <= 1'b1;
            state_q     <= ST_ONE_RST;
            fr_start_q  <= 1'b1;
          end else begin
            tmo_cnt <= tmo_cnt + TW'(1);
          end
        end
        ST_ONE_RD: if (fr_done) begin
          sample_data  <= rx_word;
          sample_valid <= 1'b1;
          state_q      <= ST_ONE_RST;
          fr_start_q   <= 1'b1;
        end
        ST_ONE_RST: if (fr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      // requests are latched last so a new pulse is never lost
      if (cfg_req) begin
        cfg_pend <= 1'b1;
        ratio_q  <= cfg_ratio;
      end
      if (start_req)  start_pend  <= 1'b1;
      if (single_req) single_pend <= 1'b1;
      if (stop_req && in_stream) stop_pend <= 1'b1;
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_quiet_sync_R5: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> !xfer_req);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    pick_vld |-> !streaming);

  assert_ovr_only_read_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(overrun_cnt) |-> ($past(state_q) == ST_STR_RD));

endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_req = 1'b0;
  logic [15:0] cfg_ratio = 16'd0;
  logic [7:0]  sync_len = 8'd5;
  logic        start_req = 1'b0, stop_req = 1'b0, single_req = 1'b0;
  logic        drdy = 1'b0;
  logic        xfer_ack;
  logic [7:0]  xfer_rx;
  logic        xfer_req, xfer_last, sync_out, ready, streaming;
  logic        sample_valid, timeout_err;
  logic [7:0]  xfer_tx, overrun_cnt;
  logic [23:0] sample_data;

  int checks = 0, failures = 0;
  logic [7:0] log_tx [256];
  logic [7:0] log_rx [256];
  logic       log_last [256];
  int log_n = 0;
  int smp_cnt = 0;
  logic [23:0] smp_last = '0;
  int sync_run = 0, sync_last = 0, sync_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.TIMEOUT_CYC(300)) uut (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_ratio(cfg_ratio),
    .sync_len(sync_len), .start_req(start_req), .stop_req(stop_req),
    .single_req(single_req), .drdy(drdy), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_last(xfer_last),
    .sync_out(sync_out), .ready(ready), .streaming(streaming),
    .sample_data(sample_data), .sample_valid(sample_valid),
    .overrun_cnt(overrun_cnt), .timeout_err(timeout_err)
  );

  // serial master model: acknowledge each byte two cycles after the request
  initial begin
    int gap;
    logic [7:0] seed;
    gap = 0; seed = 8'h5A; xfer_ack = 1'b0; xfer_rx = 8'h00;
    forever begin
      @(posedge clk); #1;
      if (xfer_ack) xfer_ack = 1'b0;
      else if (xfer_req) begin
        gap++;
        if (gap >= 2) begin
          gap = 0;
          seed = seed + 8'h3B;
          xfer_rx = seed;
          xfer_ack = 1'b1;
          log_tx[log_n] = xfer_tx; log_rx[log_n] = seed;
          log_last[log_n] = xfer_last;
          log_n++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (sample_valid) begin smp_cnt++; smp_last = sample_data; end
    if (sync_out) begin
      sync_run++;
      if (xfer_req) sync_bad++;
    end else if (sync_run != 0) begin
      sync_last = sync_run; sync_run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic chk_wr(input string req, input int i, input logic [7:0] a, input logic [7:0] d);
    check(req, {24'd0, log_tx[i]}, {24'd0, a});
    check(req, {24'd0, log_tx[i+1]}, {24'd0, d});
    check({req, " last"}, {30'd0, log_last[i], log_last[i+1]}, 32'd1);
  endtask

  task automatic chk_rd4(input string req, input int i);
    check(req, {log_tx[i], log_tx[i+1], log_tx[i+2], log_tx[i+3]}, 32'h6C000000);
    check({req, " last"}, {28'd0, log_last[i], log_last[i+1], log_last[i+2], log_last[i+3]}, 32'd1);
  endtask

  task automatic pulse_drdy(input int hi);
    @(negedge clk) drdy = 1'b1;
    repeat (hi) @(negedge clk);
    drdy = 1'b0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R1 reset ready", {31'd0, ready}, 32'd0);
    check("R1 reset req", {31'd0, xfer_req}, 32'd0);
    check("R5 reset sync", {31'd0, sync_out}, 32'd0);
    check("R7 reset valid", {31'd0, sample_valid}, 32'd0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_boot();
    wait_log(8);
    wait_ready();
    chk_wr("R1 soft reset a", 0, 8'h1D, 8'h03);
    chk_wr("R1 soft reset b", 2, 8'h1D, 8'h02);
    chk_wr("R3 boot power", 4, 8'h15, 8'h22);
    chk_wr("R4 boot filter", 6, 8'h19, 8'h02);
    check("R6 sync width 5", sync_last, 5);
    check("R5 quiet during sync", sync_bad, 0);
  endtask

  task automatic t_cfg(input string req, input int r, input logic [7:0] p, input logic [7:0] f,
                       input int slen);
    int n0;
    n0 = log_n;
    @(negedge clk) begin cfg_ratio = 16'(r); sync_len = 8'(slen); cfg_req = 1'b1; end
    @(negedge clk) cfg_req = 1'b0;
    wait_log(n0 + 4);
    wait_ready();
    chk_wr({req, " R2 R3 power"}, n0, 8'h15, p);
    chk_wr({req, " R2 R4 filter"}, n0 + 2, 8'h19, f);
    check({req, " R6 sync width"}, sync_last, (slen < 2) ? 2 : slen);
    check({req, " R5 quiet"}, sync_bad, 0);
  endtask

  task automatic t_stream();
    int n0, s0, m;
    logic [7:0] o0;
    n0 = log_n;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    wait_log(n0 + 2);
    while (!streaming) @(negedge clk);
    chk_wr("R7 enter stream", n0, 8'h14, 8'h01);
    for (int k = 0; k < 3; k++) begin
      s0 = smp_cnt; m = log_n;
      pulse_drdy(2);
      while (smp_cnt == s0) @(negedge clk);
      check("R7 dummy bytes", {8'd0, log_tx[m], log_tx[m+1], log_tx[m+2]}, 32'd0);
      check("R13 last on third", {29'd0, log_last[m], log_last[m+1], log_last[m+2]}, 32'd1);
      check("R7 sample value", {8'd0, smp_last}, {8'd0, log_rx[m], log_rx[m+1], log_rx[m+2]});
      repeat (3) @(negedge clk);
      check("R7 one strobe", smp_cnt, s0 + 1);
    end
    // R8: second edge lands during the read
    o0 = overrun_cnt; s0 = smp_cnt; m = log_n;
    pulse_drdy(1);
    repeat (2) @(negedge clk);
    pulse_drdy(2);
    repeat (30) @(negedge clk);
    check("R8 overrun count", {24'd0, overrun_cnt}, {24'd0, o0 + 8'd1});
    check("R8 single sample", smp_cnt, s0 + 1);
    check("R8 single frame", log_n, m + 3);
    // R10: config held off while streaming
    m = log_n;
    @(negedge clk) begin cfg_ratio = 16'd16; sync_len = 8'd3; cfg_req = 1'b1; end
    @(negedge clk) cfg_req = 1'b0;
    repeat (30) @(negedge clk);
    check("R10 no bytes while streaming", log_n, m);
    check("R10 still streaming", {31'd0, streaming}, 32'd1);
    s0 = smp_cnt;
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    wait_log(m + 8);
    wait_ready();
    chk_rd4("R9 stop frame", m);
    chk_wr("R10 deferred power", m + 4, 8'h15, 8'h33);
    chk_wr("R10 deferred filter", m + 6, 8'h19, 8'h10);
    check("R9 no sample on stop", smp_cnt, s0);
    m = log_n;
    pulse_drdy(2);
    repeat (20) @(negedge clk);
    check("R9 drdy ignored after stop", log_n, m);
    check("R9 no sample after stop", smp_cnt, s0);
  endtask

  task automatic t_single();
    int n0, s0;
    n0 = log_n; s0 = smp_cnt;
    @(negedge clk) single_req = 1'b1;
    @(negedge clk) single_req = 1'b0;
    wait_log(n0 + 2);
    repeat (6) @(negedge clk);
    pulse_drdy(2);
    wait_log(n0 + 8);
    wait_ready();
    chk_wr("R11 one-shot", n0, 8'h18, 8'h01);
    chk_rd4("R11 data read", n0 + 2);
    chk_wr("R11 restore", n0 + 6, 8'h18, 8'h00);
    check("R11 sample", {8'd0, smp_last}, {8'd0, log_rx[n0+3], log_rx[n0+4], log_rx[n0+5]});
    check("R11 one sample", smp_cnt, s0 + 1);
    check("R12 no timeout", {31'd0, timeout_err}, 32'd0);
  endtask

  task automatic t_timeout();
    int n0, s0;
    n0 = log_n; s0 = smp_cnt;
    @(negedge clk) single_req = 1'b1;
    @(negedge clk) single_req = 1'b0;
    wait_log(n0 + 2);
    repeat (100) @(negedge clk);
    check("R12 not early", {31'd0, timeout_err}, 32'd0);
    wait_log(n0 + 4);
    wait_ready();
    chk_wr("R12 one-shot", n0, 8'h18, 8'h01);
    chk_wr("R12 restore", n0 + 2, 8'h18, 8'h00);
    check("R12 timeout flag", {31'd0, timeout_err}, 32'd1);
    check("R12 no sample", smp_cnt, s0);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_cfg("20",    20,    8'h33, 8'h10, 4);
    t_cfg("24tie", 24,    8'h33, 8'h10, 0);
    t_cfg("48tie", 48,    8'h33, 8'h20, 2);
    t_cfg("130",   130,   8'h33, 8'h01, 3);
    t_cfg("2000",  2000,  8'h22, 8'h04, 6);
    t_cfg("6000",  6000,  8'h22, 8'h05, 2);
    t_cfg("8000",  8000,  8'h12, 8'h05, 1);
    t_cfg("40000", 40000, 8'h00, 8'h05, 7);
    t_stream();
    t_single();
    t_timeout();
    t_single();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule